// File: doc/BRIEF.md
# Decoded Divide-by-Eight Twisted-Ring Counter

This block is a four-stage twisted-ring (Johnson) counter that divides a slow count input by eight. It has eight decoded phase lines, exactly one of which is high for each of the eight counts. It also has an active-low carry line that toggles once per full turn, so that stages can be cascaded.

The count is driven by two level inputs: a count line and an active-low inhibit. Both are brought into the system clock domain and combined into one term, which is high when the count line is high and the inhibit is low. Each low-to-high change of that term advances the counter by one step. As a result, the counter steps on a rising count line while the inhibit is low. It also steps on a falling inhibit while the count line is high. No other combination has any effect.

A clear input resets the count to zero at once, without waiting for a clock. It holds the count at zero for as long as it stays high. The feedback term is shaped so that any illegal ring pattern falls back into the legal eight-state cycle.

Top module: `jdc_div8`

## Requirements
- R1: While the system reset is low, phase_o reads 8'b0000_0001 (count 0) and carry_n_o reads 1.
- R2: A rising edge of tick_i while tick_en_n_i is low advances the count by one. The change shows at the outputs after the third rising system-clock edge following the input change.
- R3: A falling edge of tick_en_n_i while tick_i is high advances the count by one, with the same latency as R2.
- R4: The following leave the outputs unchanged: edges of tick_i while tick_en_n_i is high, edges of tick_en_n_i while tick_i is low, a falling tick_i, and a rising tick_en_n_i.
- R5: The count runs 0,1,…,7 and then wraps to 0. phase_o bit k is high for count k and all other bits are low.
- R6: carry_n_o is 1 for counts 0 to 3 and 0 for counts 4 to 7.
- R7: clear_i high forces count 0 at the outputs without waiting for a system-clock edge. Count 0 is held while clear_i stays high, whatever the count inputs do.
- R8: After clear_i falls, the first qualifying count event moves phase_o from bit 0 to bit 1.
- R9: The internal ring holds bits s3..s0, with s0 the stage that receives the feedback. Legal states shift left with new s0 = NOT s3, giving the states 0000,0001,0011,0111,1111,1110,1100,1000 for counts 0 to 7. Any illegal pattern reaches a legal state within five count events; starting from 1001, five events reach 1100 (count 6).
- R10: A count term that stays high for many system clocks advances the count only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the count inputs |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| tick_i | input | 1 | Count line (level, asynchronous to clk_i) |
| tick_en_n_i | input | 1 | Active-low count inhibit (level, asynchronous to clk_i) |
| clear_i | input | 1 | Active-high asynchronous clear of the count |
| phase_o | output | 8 | One-hot decoded count, bit k high at count k |
| carry_n_o | output | 1 | Active-low carry, low for the upper half of the cycle |

## Verification
The decode is combinational from the ring stages, so a corrupted ring appears at the ports in the same cycle. It shows as zero or two phase lines high, or as a carry level that disagrees with the active phase line. A lost or doubled count event has no immediate symptom. It becomes visible three system clocks after the input change, when phase_o is off by one from a reference that counts term edges independently. The reference also covers any error in the synchroniser depth, because every count is checked against a cycle-exact latency. The self-correction path is exercised by planting an illegal pattern in the ring and counting events until a single line is high again.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

  // Raw and synchronised levels of the count controls
  typedef struct packed {
    logic lvl;    // count line level
    logic inh_n;  // active-low inhibit level
  } cnt_pins_t;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_RING_BITS   = 4;

endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/jdc_event.sv
module jdc_event
  import jdc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  cnt_pins_t pins_i,
  output logic      step_o
);

  logic term;
  logic term_q;

  // Count term: line high while inhibit low
  assign term = pins_i.lvl & ~pins_i.inh_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) term_q <= 1'b0;
    else         term_q <= term;
  end

  assign step_o = term & ~term_q;

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o); // R10

endmodule

// File: rtl/jdc_ring.sv
module jdc_ring #(
  parameter int unsigned RING_BITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 step_i,
  output logic [RING_BITS-1:0] state_o
);

  logic [RING_BITS-1:0] state_q;
  logic                 fb;
  logic [RING_BITS-1:0] state_nxt;

  // Inverted tail feeds stage 0; the extra term steers illegal patterns back
  assign fb        = ~state_q[RING_BITS-1] & (state_q[0] | ~state_q[RING_BITS-2]);
  assign state_nxt = {state_q[RING_BITS-2:0], fb};

  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni || clear_i) state_q <= '0;
    else if (step_i)        state_q <= state_nxt;
  end

  assign state_o = state_q;

  function automatic logic ring_ok(input logic [RING_BITS-1:0] s);
    return $countones(s[RING_BITS-1:1] ^ s[RING_BITS-2:0]) <= 1;
  endfunction

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> (state_q == '0)); // R7

  AST_LEGAL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && ring_ok(state_q)) |=>
      (clear_i || (ring_ok(state_q) && state_q != $past(state_q)))); // R5

endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
  parameter int unsigned RING_BITS = 4,
  localparam int unsigned OUTS     = 2 * RING_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [RING_BITS-1:0] state_i,
  output logic [OUTS-1:0]      phase_o,
  output logic                 carry_n_o
);

  // Each phase line looks at the one pair of adjacent stages that marks its count
  for (genvar k = 0; k < OUTS; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign phase_o[k] = ~state_i[RING_BITS-1] & ~state_i[0];
    end else if (k < RING_BITS) begin : g_fill
      assign phase_o[k] = state_i[k-1] & ~state_i[k];
    end else if (k == RING_BITS) begin : g_full
      assign phase_o[k] = state_i[RING_BITS-1] & state_i[0];
    end else begin : g_drain
      assign phase_o[k] = ~state_i[k-RING_BITS-1] & state_i[k-RING_BITS];
    end
  end

  assign carry_n_o = ~state_i[RING_BITS-1];

  function automatic logic ring_ok(input logic [RING_BITS-1:0] s);
    return $countones(s[RING_BITS-1:1] ^ s[RING_BITS-2:0]) <= 1;
  endfunction

  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_ok(state_i) |-> $onehot(phase_o)); // R5

  AST_CARRY_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_ok(state_i) |-> (carry_n_o == ~|phase_o[OUTS-1:RING_BITS])); // R6

endmodule

// File: rtl/jdc_div8.sv
module jdc_div8
  import jdc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned RING_BITS   = DEF_RING_BITS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     tick_en_n_i,
  input  logic                     clear_i,
  output logic [2*RING_BITS-1:0]   phase_o,
  output logic                     carry_n_o
);

  localparam int unsigned PIN_W = $bits(cnt_pins_t);

  cnt_pins_t            pins_raw;
  cnt_pins_t            pins_syn;
  logic                 step;
  logic [RING_BITS-1:0] ring_state;

  assign pins_raw.lvl   = tick_i;
  assign pins_raw.inh_n = tick_en_n_i;

  jdc_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_syn)
  );

  jdc_event u_event (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (pins_syn),
    .step_o (step)
  );

  jdc_ring #(
    .RING_BITS (RING_BITS)
  ) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .step_i  (step),
    .state_o (ring_state)
  );

  jdc_decode #(
    .RING_BITS (RING_BITS)
  ) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (ring_state),
    .phase_o   (phase_o),
    .carry_n_o (carry_n_o)
  );

endmodule

// File: tb/jdc_div8_tb_top.sv
`timescale 1ns/1ps
module jdc_div8_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       tick_en_n = 1'b1;
  logic       clear = 1'b0;
  logic [7:0] phase;
  logic       carry_n;

  int vec = 0;
  int bad = 0;

  // Reference: term history and count
  int mdl_cnt = 0;
  bit h1 = 0, h2 = 0, h3 = 0;
  bit mdl_on = 0;

  always #2 clk = ~clk;

  jdc_div8 dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .tick_en_n_i (tick_en_n),
    .clear_i     (clear),
    .phase_o     (phase),
    .carry_n_o   (carry_n)
  );

  function automatic logic [8:0] exp_of(input int n);
    return {(n < 4) ? 1'b1 : 1'b0, 8'(1 << n)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; mdl_cnt = 0;
    end else begin
      if (clear)          mdl_cnt = 0;
      else if (h2 && !h3) mdl_cnt = (mdl_cnt + 1) % 8;
      h3 = h2; h2 = h1; h1 = tick && !tick_en_n;
    end
  end

  always @(negedge clk) begin
    if (mdl_on) begin
      vec++;
      if ({carry_n, phase} !== exp_of(mdl_cnt)) begin
        bad++;
        $display("FAIL R5/R6 per-cycle: act=%b_%b exp=%b", carry_n, phase, exp_of(mdl_cnt));
      end
    end
  end

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic go(input int n);
    repeat (n) begin
      @(negedge clk);
      #0.5;
    end
  endtask

  task automatic tick_pulse(input int n);
    repeat (n) begin
      tick = 1'b1; go(3);
      tick = 1'b0; go(3);
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++; vec++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    go(3);
    chk("R1 reset state", {carry_n, phase}, exp_of(0));
    rst_n = 1'b1;
    mdl_on = 1;
    go(2);

    // R2: rising count line with inhibit low
    tick_en_n = 1'b0;
    go(2);
    tick = 1'b1;
    go(2);
    chk("R2 not before third edge", {carry_n, phase}, exp_of(0));
    go(1);
    chk("R2 after third edge", {carry_n, phase}, exp_of(1));
    tick = 1'b0; go(3);
    tick_pulse(2);
    chk("R2 three events", {carry_n, phase}, exp_of(3));
    tick_pulse(1);
    chk("R6 carry low at count 4", {carry_n, phase}, exp_of(4));
    tick_pulse(3);
    chk("R6 carry low at count 7", {carry_n, phase}, exp_of(7));
    tick_pulse(1);
    chk("R5 wrap to count 0", {carry_n, phase}, exp_of(0));
    tick_pulse(2);

    // R4: ignored combinations
    tick_en_n = 1'b1; go(3);
    tick_pulse(3);
    chk("R4 line edges while inhibited", {carry_n, phase}, exp_of(2));
    tick_en_n = 1'b0; go(3);
    tick_en_n = 1'b1; go(3);
    chk("R4 inhibit edges while line low", {carry_n, phase}, exp_of(2));

    // R3: falling inhibit with line high
    tick = 1'b1; go(3);
    tick_en_n = 1'b0; go(4);
    chk("R3 falling inhibit steps", {carry_n, phase}, exp_of(3));
    tick = 1'b0; go(4);
    chk("R4 falling line no step", {carry_n, phase}, exp_of(3));
    tick_en_n = 1'b1; go(3);
    tick = 1'b1; go(3);
    tick_en_n = 1'b0; go(4);
    chk("R3 second falling inhibit", {carry_n, phase}, exp_of(4));
    tick_en_n = 1'b1; go(4);
    chk("R4 rising inhibit no step", {carry_n, phase}, exp_of(4));

    // R10: long high term counts once
    tick = 1'b0; go(2);
    tick_en_n = 1'b0; go(3);
    tick = 1'b1; go(20);
    chk("R10 held term single step", {carry_n, phase}, exp_of(5));
    tick = 1'b0; go(3);

    // R7: asynchronous clear
    clear = 1'b1;
    #0.5;
    chk("R7 clear without clock edge", {carry_n, phase}, exp_of(0));
    go(1);
    tick_pulse(2);
    tick = 1'b1; go(2);
    tick_en_n = 1'b1; go(2);
    tick_en_n = 1'b0; go(2);
    chk("R7 held during count activity", {carry_n, phase}, exp_of(0));
    tick = 1'b0; go(4);
    clear = 1'b0; go(3);
    chk("R8 zero after release", {carry_n, phase}, exp_of(0));
    tick_pulse(1);
    chk("R8 first event goes to bit 1", {carry_n, phase}, exp_of(1));

    // R9: illegal pattern recovery
    mdl_on = 0;
    go(2);
    force dut_i.u_ring.state_q = 4'b1001;
    go(1);
    release dut_i.u_ring.state_q;
    go(1);
    tick_pulse(5);
    chk("R9 recovered to count 6", {carry_n, phase}, exp_of(6));
    mdl_cnt = 6;
    mdl_on = 1;
    tick_pulse(2);
    chk("R9 legal cycle resumes", {carry_n, phase}, exp_of(0));

    go(2);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule